// File: doc/BRIEF.md
# Address-Stepping Burst Reader for Asynchronous SRAM

This block reads a run of consecutive words from an asynchronous SRAM without toggling a read strobe. After a start pulse it drives the first address and pulls output enable low. From then on it advances the address by one for each word, waits a programmable number of clocks after each address change, and captures whatever the memory drives on the data pins. Output enable stays low for the whole run.

Each captured word comes out with a one-cycle valid pulse and the address it was read from. A done pulse marks the end of the run. Output enable goes high in the same cycle as the done pulse, and the address lines keep their final value afterwards. Write requests are always refused and raise an error flag. A run of zero words completes at once without touching the bus.

Top module: `crs_burst_reader`

## Requirements
- R1: While reset is asserted and after it is released, oe_no is 1, addr_o is 0, and word_valid_o, done_o, wr_err_o and busy_o are 0.
- R2: A start_i seen while idle with word_cnt_i > 0 puts base_addr_i on addr_o and drives oe_no to 0 in the next cycle. oe_no then stays 0 without interruption until the done pulse.
- R3: After each captured word except the last, addr_o increments by one, wrapping modulo 2^AW. word_addr_o of the k-th word (k from 0) is base+k. After the last word, addr_o keeps its final value, including while idle.
- R4: Data is sampled exactly S clocks after each address change, where S is settle_i latched at start and a value of 0 counts as 1. The word appears on word_o together with a single-cycle word_valid_o pulse.
- R5: A burst produces exactly word_cnt_i valid pulses.
- R6: done_o pulses for one cycle, one clock after the last valid pulse. oe_no returns to 1 in that same cycle, and oe_no only rises together with done_o.
- R7: start_i with word_cnt_i = 0 gives a done_o pulse in the next cycle. oe_no stays 1, addr_o does not change, and there is no valid pulse.
- R8: A write request on wr_req_i gives wr_err_o = 1 in the next cycle. It has no other effect: the bus is not driven and a running burst is not disturbed.
- R9: start_i while a burst is running is ignored.
- R10: busy_o is 1 from the cycle after an accepted start up to the cycle before done_o, and it is 0 when done_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (only acted on while idle) |
| base_addr_i | input | AW | First address of the burst |
| word_cnt_i | input | CW | Number of words to read |
| settle_i | input | SW | Clocks from an address change to the data sample (0 counts as 1) |
| wr_req_i | input | 1 | Write request, always refused |
| rd_data_i | input | DW | Data pins driven by the memory |
| addr_o | output | AW | Address lines to the memory |
| oe_no | output | 1 | Output enable, active low |
| word_o | output | DW | Captured word |
| word_addr_o | output | AW | Address the captured word was read from |
| word_valid_o | output | 1 | One-cycle pulse per captured word |
| done_o | output | 1 | One-cycle pulse at the end of a burst |
| wr_err_o | output | 1 | Write rejected |
| busy_o | output | 1 | Burst in progress |

## Verification
The bench models the memory so that it drives a garbage pattern until the address has been stable for S-1 clocks. A design that samples one clock early therefore captures the wrong word instead of silently passing. Directed runs cover a settle value of 0 (a design that took it literally would stall or count 16), an address wrap at the top of the space, and a zero-length burst (a wrong design would pulse output enable or step the address). Further directed runs inject a write and a second start in the middle of a burst; a design that honoured either would change the address sequence or end the burst early. Randomized bursts check the exact cycle of every valid pulse and the done pulse, and that output enable is released in the same cycle as done and not one cycle off.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_TAIL   = 2'd2
  } crs_state_e;
endpackage

// File: rtl/crs_settle_timer.sv
module crs_settle_timer #(
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] settle_i,
  input  logic          reload_i,
  input  logic          run_i,
  output logic          expire_o
);
  localparam logic [SW-1:0] ONE = SW'(1);

  logic [SW-1:0] set_q, tmr_q, eff;

  // zero settle is treated as one clock
  assign eff = (settle_i == '0) ? ONE : settle_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= ONE;
      tmr_q <= ONE;
    end else if (start_i) begin
      set_q <= eff;
      tmr_q <= eff;
    end else if (reload_i) begin
      tmr_q <= set_q;
    end else if (run_i && tmr_q != ONE) begin
      tmr_q <= tmr_q - ONE;
    end
  end

  assign expire_o = run_i && (tmr_q == ONE);
endmodule

// File: rtl/crs_addr_step.sv
module crs_addr_step #(
  parameter int AW = 20,
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;
  logic [CW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (load_i) begin
      addr_q <= base_i;
      rem_q  <= cnt_i;
    end else if (step_i) begin
      addr_q <= addr_q + AW'(1);
      rem_q  <= rem_q - CW'(1);
    end
  end

  assign addr_o = addr_q;
  assign last_o = (rem_q == CW'(1));
endmodule

// File: rtl/crs_capture.sv
module crs_capture #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] data_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] word_o,
  output logic [AW-1:0] word_addr_o,
  output logic          valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o      <= '0;
      word_addr_o <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= cap_i;
      if (cap_i) begin
        word_o      <= data_i;
        word_addr_o <= addr_i;
      end
    end
  end
endmodule

// File: rtl/crs_burst_reader.sv
module crs_burst_reader
  import crs_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 8,
  parameter int SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic [CW-1:0] word_cnt_i,
  input  logic [SW-1:0] settle_i,
  input  logic          wr_req_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] addr_o,
  output logic          oe_no,
  output logic [DW-1:0] word_o,
  output logic [AW-1:0] word_addr_o,
  output logic          word_valid_o,
  output logic          done_o,
  output logic          wr_err_o,
  output logic          busy_o
);
  crs_state_e st_q, st_n;
  logic accept, go, capture, expire, last, step;
  logic oe_n_q, done_q, wr_err_q;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign go      = accept && (word_cnt_i != '0);
  assign capture = (st_q == ST_SETTLE) && expire;
  assign step    = capture && !last;

  always_comb begin
    st_n = st_q;
    unique case (st_q)
      ST_IDLE:   if (go) st_n = ST_SETTLE;
      ST_SETTLE: if (capture && last) st_n = ST_TAIL;
      ST_TAIL:   st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      oe_n_q   <= 1'b1;
      done_q   <= 1'b0;
      wr_err_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      oe_n_q   <= (st_n == ST_IDLE);
      done_q   <= (st_q == ST_TAIL) || (accept && !go);
      wr_err_q <= wr_req_i;  // writes are never performed in this mode
    end
  end

  crs_settle_timer #(.SW(SW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (go),
    .settle_i (settle_i),
    .reload_i (step),
    .run_i    (st_q == ST_SETTLE),
    .expire_o (expire)
  );

  crs_addr_step #(.AW(AW), .CW(CW)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go),
    .base_i (base_addr_i),
    .cnt_i  (word_cnt_i),
    .step_i (step),
    .addr_o (addr_o),
    .last_o (last)
  );

  crs_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cap_i       (capture),
    .data_i      (rd_data_i),
    .addr_i      (addr_o),
    .word_o      (word_o),
    .word_addr_o (word_addr_o),
    .valid_o     (word_valid_o)
  );

  assign oe_no    = oe_n_q;
  assign done_o   = done_q;
  assign wr_err_o = wr_err_q;
  assign busy_o   = (st_q != ST_IDLE);
endmodule

// File: rtl/crs_burst_reader_chk.sv
module crs_burst_reader_chk #(
  parameter int AW = 20,
  parameter int SW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [SW-1:0] settle_i,
  input logic          wr_req_i,
  input logic [AW-1:0] addr_o,
  input logic          oe_no,
  input logic [AW-1:0] word_addr_o,
  input logic          word_valid_o,
  input logic          done_o,
  input logic          wr_err_o,
  input logic          busy_o
);
  logic [AW-1:0] a_q, prev_waddr;
  logic [5:0]    since_chg;
  logic [SW-1:0] slat;
  logic          first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q        <= '0;
      since_chg  <= '1;
      slat       <= SW'(1);
      first_q    <= 1'b1;
      prev_waddr <= '0;
    end else begin
      a_q <= addr_o;
      if (addr_o != a_q) since_chg <= 6'd1;
      else if (since_chg != '1) since_chg <= since_chg + 6'd1;
      if (start_i && !busy_o) begin
        slat    <= (settle_i == '0) ? SW'(1) : settle_i;
        first_q <= 1'b1;
      end else if (word_valid_o) begin
        first_q    <= 1'b0;
        prev_waddr <= word_addr_o;
      end
    end
  end

  assert_oe_low_on_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> !oe_no);
  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_o && !first_q) |-> (word_addr_o == prev_waddr + AW'(1)));
  assert_settle_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_o |-> (since_chg >= 6'(slat)));
  assert_oe_rise_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_no) |-> done_o);
  assert_done_oe_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> oe_no);
  assert_no_valid_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, word_valid_o}));
  assert_wr_reject_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> wr_err_o);
  assert_wr_no_bus_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && !busy_o && !start_i) |=> (oe_no && $stable(addr_o)));
  assert_idle_on_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind crs_burst_reader crs_burst_reader_chk #(.AW(AW), .SW(SW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .settle_i     (settle_i),
  .wr_req_i     (wr_req_i),
  .addr_o       (addr_o),
  .oe_no        (oe_no),
  .word_addr_o  (word_addr_o),
  .word_valid_o (word_valid_o),
  .done_o       (done_o),
  .wr_err_o     (wr_err_o),
  .busy_o       (busy_o)
);

// File: tb/crs_burst_reader_tb.sv
`timescale 1ns/1ps
module crs_burst_reader_tb;
  localparam int AW = 20, DW = 16, CW = 8, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] word_cnt = '0;
  logic [SW-1:0] settle = '0;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] addr, word_addr;
  logic oe_n, valid, done, wr_err, busy;
  logic [DW-1:0] word;

  int total = 0, bad = 0;
  int s_cur = 1, sc = 100;
  logic [AW-1:0] prev_a = '0;
  bit finished = 0;

  always #4 clk = ~clk;

  crs_burst_reader #(.AW(AW), .DW(DW), .CW(CW), .SW(SW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_addr),
    .word_cnt_i(word_cnt), .settle_i(settle), .wr_req_i(wr_req), .rd_data_i(rd_data),
    .addr_o(addr), .oe_no(oe_n), .word_o(word), .word_addr_o(word_addr),
    .word_valid_o(valid), .done_o(done), .wr_err_o(wr_err), .busy_o(busy)
  );

  function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
    return (a[15:0] * 16'd31) ^ 16'h5A3C ^ {a[19:16], 12'h000};
  endfunction

  // memory model: data is valid only once the address has been stable S-1 clocks
  always @(posedge clk) begin
    if (addr != prev_a) sc <= 1;
    else if (sc < 1000) sc <= sc + 1;
    prev_a <= addr;
  end
  always_comb rd_data = (sc >= s_cur - 1) ? mem_f(addr) : 16'hBAD0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic burst(input logic [AW-1:0] base, input int n, input int s,
                       input bit inj_wr, input bit inj_start);
    int se = (s == 0) ? 1 : s;
    int last = se * n + 1;
    int widx = 0;
    logic [AW-1:0] a0;
    @(negedge clk);
    a0 = addr;
    s_cur = se; base_addr = base; word_cnt = CW'(n); settle = SW'(s); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) begin
      chk(done == 1'b1, "R7 done", done, 1);
      chk(oe_n == 1'b1 && addr == a0 && valid == 1'b0, "R7 no bus", addr, a0);
      @(negedge clk);
      chk(done == 1'b0 && oe_n == 1'b1 && addr == a0, "R7 single pulse", done, 0);
      return;
    end
    for (int j = 0; j <= last; j++) begin
      bit ev;
      int ai;
      if (j > 0) @(negedge clk);
      if (j == 1 && inj_wr) wr_req = 1'b1;
      if (j == 1 && inj_start) begin
        start = 1'b1; base_addr = base ^ 20'h0F0F0; word_cnt = 8'd1;
      end
      if (j == 2) begin
        if (inj_wr) chk(wr_err == 1'b1, "R8 err in burst", wr_err, 1);
        wr_req = 1'b0; start = 1'b0;
      end
      ev = (j > 0) && (j % se == 0) && (j <= se * n);
      chk(valid == ev, "R4 valid timing", valid, ev);
      if (ev) begin
        chk(word_addr == AW'(base + widx), "R3 word addr", word_addr, AW'(base + widx));
        chk(word == mem_f(AW'(base + widx)), "R4 word data", word, mem_f(AW'(base + widx)));
        widx++;
      end
      ai = (j / se < n - 1) ? j / se : n - 1;
      chk(addr == AW'(base + ai), "R3 addr", addr, AW'(base + ai));
      chk(oe_n == (j == last), "R2 R6 oe", oe_n, (j == last));
      chk(done == (j == last), "R6 done", done, (j == last));
      chk(busy == (j < last), "R10 busy", busy, (j < last));
    end
    chk(widx == n, "R5 word count", widx, n);
    @(negedge clk);
    chk(addr == AW'(base + n - 1) && oe_n && !valid && !done, "R3 hold", addr, AW'(base + n - 1));
  endtask

  initial begin
    int dummy;
    dummy = $urandom(32'h1F2E);
    repeat (3) @(negedge clk);
    chk(oe_n == 1'b1 && addr == '0 && !valid && !done && !wr_err && !busy, "R1 in reset", addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(oe_n == 1'b1 && addr == '0 && !valid && !done && !wr_err && !busy, "R1 after reset", addr, 0);

    burst(20'h00100, 2, 1, 0, 0);
    burst(20'h00200, 4, 0, 0, 0);
    burst(20'hFFFFE, 4, 3, 0, 0);
    burst(20'h12345, 3, 15, 0, 0);
    burst(20'h00500, 0, 5, 0, 0);
    burst(20'h00600, 5, 2, 1, 0);
    burst(20'h00700, 3, 4, 0, 1);  // R9 second start ignored
    burst(20'h00800, 1, 7, 0, 0);

    // R8 write while idle
    @(negedge clk);
    begin
      logic [AW-1:0] a0;
      a0 = addr;
      wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      chk(wr_err == 1'b1, "R8 err idle", wr_err, 1);
      chk(oe_n == 1'b1 && addr == a0 && !busy, "R8 no bus idle", addr, a0);
      @(negedge clk);
      chk(wr_err == 1'b0 && addr == a0, "R8 err clears", wr_err, 0);
    end

    for (int i = 0; i < 24; i++)
      burst(AW'($urandom), $urandom_range(0, 9), $urandom_range(0, 15),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule